// File: doc/BRIEF.md
# Indexed Host Register Port

This block connects an external host processor to a bank of control registers. The host uses an 8-bit data bus, an active-low chip select, separate write and read strobes, and one address line. With the address line high, a write loads an index. With the address line low, a write reaches the register that index selects and a read returns that register. An index stays in place until the host writes a new one. This lets the host write or read the same register repeatedly without re-indexing.

Three indexes are stream windows. A byte written through one of them is not stored. It is passed out on a one-cycle packet-buffer port tagged with the window number, so a whole packet can follow a single index write. Internal logic raises packet and end-of-song requests as single-cycle pulses. These collect in a read-only request register that drives an active-low interrupt line. Reading that register releases the interrupt and clears only the bits the host actually saw. Another read-only index echoes the index of the host's most recent data write.

Top module: `host_index_port`

## Requirements
- R1: After reset every index reads 0x00, `irq_n` is high and `ready` is low.
- R2: A data write stores the byte at the writable indexes 0x03 to 0x10 and 0x14 to 0x19, and a later read of that index returns it.
- R3: Strobes that occur while `cs_n` is high change no register, index or echo value.
- R4: Data writes to read-only or reserved indexes are ignored. Reads of reserved indexes (0x00 to 0x02, 0x1B, 0x1C, 0x1E, 0x1F, 0x20 and above) and of the stream windows return 0x00.
- R5: The request pulse inputs `evt[0]`, `evt[1]`, `evt[2]` and `evt[3]` set bits 0, 1, 2 and 5 of the request register at index 0x1A. `irq_n` is low while any of these bits is set.
- R6: A read of index 0x1A returns the pending bits, captured when the read strobe falls. When the strobe rises, exactly those bits are cleared, so `irq_n` goes high if nothing else is pending.
- R7: A request pulse that arrives in the same cycle as the clear of a request-register read stays pending and keeps `irq_n` low.
- R8: Each data write to index 0x11, 0x12 or 0x13 gives one cycle of `stream_we`, with `stream_sel` equal to 1, 2 or 3 and `stream_data` equal to the byte. The index stays in place for the next byte.
- R9: Index 0x1D reads back the index targeted by the most recent data write.
- R10: `ready` is high exactly while index 0x14 holds 0x4D.
- R11: A strobe acts only after its rising edge has passed a two-flop synchronizer. Nothing changes while the strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, acts on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | High selects the index, low selects the data window |
| din | input | DW | Write data from host |
| dout | output | DW | Read data to host |
| evt | input | 4 | Single-cycle request pulses (wave 2, wave 1, song packet, song end) |
| irq_n | output | 1 | Interrupt request, active low |
| regs_flat | output | NREG*DW | All control register values, index 0 at the LSBs |
| ready | output | 1 | Ready key has been written |
| stream_we | output | 1 | One-cycle packet byte strobe |
| stream_sel | output | 2 | Stream window number 1 to 3 |
| stream_data | output | DW | Packet byte |

## Verification
The clear at the end of a request-register read and a fresh request pulse can land on the same clock edge. The bench provokes this by holding one request bit pending, reading it, and then placing a new pulse for that bit at each offset from zero to five cycles after the read strobe rises. The expected result follows from the synchronizer depth. A pulse that arrives before the clearing edge is wiped out with the bits that were read, so `irq_n` ends high. A pulse on the clearing edge or after it must survive, so `irq_n` stays low. The bench judges every offset by the final level of `irq_n`.

// File: rtl/host_index_port.sv
module host_index_port #(
  parameter int DW = 8,
  parameter int NREG = 32,
  parameter logic [DW-1:0] READY_KEY = 8'h4D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic               a0,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      dout,
  input  logic [3:0]         evt,
  output logic               irq_n,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               ready,
  output logic               stream_we,
  output logic [1:0]         stream_sel,
  output logic [DW-1:0]      stream_data
);

  localparam int IW = $clog2(NREG);
  localparam logic [DW-1:0] IDX_REQ   = DW'('h1A);
  localparam logic [DW-1:0] IDX_ECHO  = DW'('h1D);
  localparam logic [DW-1:0] IDX_READY = DW'('h14);
  localparam logic [DW-1:0] IDX_S_LO  = DW'('h11);
  localparam logic [DW-1:0] IDX_S_HI  = DW'('h13);

  function automatic logic writable(input logic [DW-1:0] i);
    return (i >= DW'('h03) && i <= DW'('h10)) || (i >= DW'('h14) && i <= DW'('h19));
  endfunction

  logic [2:0] wr_sy, rd_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sy <= 3'b111;
      rd_sy <= 3'b111;
    end else begin
      wr_sy <= {wr_sy[1:0], wr_n};
      rd_sy <= {rd_sy[1:0], rd_n};
    end

  wire wr_rise = wr_sy[1] & ~wr_sy[2];
  wire rd_rise = rd_sy[1] & ~rd_sy[2];
  wire rd_fall = ~rd_sy[1] & rd_sy[2];
  wire idx_we  = wr_rise & ~cs_n & a0;
  wire data_we = wr_rise & ~cs_n & ~a0;

  logic [DW-1:0] idx, echo, req, snap, evt_bits;
  logic          rd_on_req;
  wire           in_stream = (idx >= IDX_S_LO) && (idx <= IDX_S_HI);

  always_comb begin
    evt_bits    = '0;
    evt_bits[0] = evt[0];
    evt_bits[1] = evt[1];
    evt_bits[2] = evt[2];
    evt_bits[5] = evt[3];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx  <= '0;
      echo <= '0;
    end else begin
      if (idx_we)  idx  <= din;
      if (data_we) echo <= idx;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] GI = DW'(g);
    if (writable(GI)) begin : g_rw
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= '0;
        else if (data_we && idx == GI) r <= din;
      assign regs_flat[g*DW +: DW] = r;
    end else begin : g_ro
      assign regs_flat[g*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req       <= '0;
      snap      <= '0;
      rd_on_req <= 1'b0;
    end else begin
      if (rd_fall && !cs_n && !a0 && idx == IDX_REQ) begin
        rd_on_req <= 1'b1;
        snap      <= req;
      end else if (rd_rise) begin
        rd_on_req <= 1'b0;
      end
      if (rd_rise && rd_on_req) req <= (req & ~snap) | evt_bits;
      else                      req <= req | evt_bits;
    end

  assign irq_n = ~|req;
  assign ready = regs_flat[int'(IDX_READY)*DW +: DW] == READY_KEY;

  always_comb begin
    if (idx == IDX_REQ)          dout = rd_on_req ? snap : req;
    else if (idx == IDX_ECHO)    dout = echo;
    else if (idx < DW'(NREG))    dout = regs_flat[idx[IW-1:0]*DW +: DW];
    else                         dout = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stream_we   <= 1'b0;
      stream_sel  <= '0;
      stream_data <= '0;
    end else begin
      stream_we <= data_we & in_stream;
      if (data_we && in_stream) begin
        stream_sel  <= idx[1:0];
        stream_data <= din;
      end
    end

  a_r5_irq_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 4'b0) |=> !irq_n);

  a_r6_clear_read_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && rd_on_req && evt == 4'b0) |=> ((req & $past(snap)) == '0));

  a_r4_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !writable(idx)) |=> $stable(regs_flat));

  a_r8_stream_sel_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stream_we |-> (stream_sel != 2'b0));

  a_r10_ready_from_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(data_we && idx == IDX_READY && din == READY_KEY));

  a_r11_no_stream_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sy[1] |=> !stream_we);

endmodule

// File: tb/host_index_port_test.sv
module host_index_port_test;
  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, rd_n = 1, a0 = 0;
  logic [7:0] din = 0;
  logic [3:0] evt = 0;
  logic [7:0] dout, stream_data;
  logic [255:0] regs_flat;
  logic irq_n, ready, stream_we;
  logic [1:0] stream_sel;

  host_index_port uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .a0(a0), .din(din), .dout(dout), .evt(evt), .irq_n(irq_n), .regs_flat(regs_flat),
    .ready(ready), .stream_we(stream_we), .stream_sel(stream_sel), .stream_data(stream_data));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, scnt = 0;
  logic [1:0] lsel;
  logic [7:0] ldata;
  logic [7:0] m [32];
  logic [7:0] last_dw = 0, m_req = 0;
  bit done = 0;

  always @(negedge clk) if (stream_we) begin scnt++; lsel = stream_sel; ldata = stream_data; end

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit wr_ok(input int i);
    return (i >= 3 && i <= 16) || (i >= 20 && i <= 25);
  endfunction

  function automatic logic [7:0] expect_rd(input int i);
    if (i == 26) return m_req;
    if (i == 29) return last_dw;
    if (i < 32 && wr_ok(i)) return m[i];
    return 8'h00;
  endfunction

  function automatic logic [7:0] map_evt(input logic [3:0] p);
    return {2'b00, p[3], 2'b00, p[2:0]};
  endfunction

  task automatic access_w(input logic a, input logic [7:0] v, input logic csn);
    @(negedge clk); cs_n = csn; a0 = a; din = v; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic set_idx(input logic [7:0] i); access_w(1'b1, i, 1'b0); endtask

  task automatic do_w(input int i, input logic [7:0] v);
    set_idx(8'(i));
    access_w(1'b0, v, 1'b0);
    last_dw = 8'(i);
    if (i < 32 && wr_ok(i)) m[i] = v;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); cs_n = 0; a0 = 0; rd_n = 0;
    repeat (4) @(negedge clk);
    v = dout;
    rd_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic read_chk(input string r, input int i);
    logic [7:0] v;
    set_idx(8'(i));
    rd(v);
    chk(r, v, expect_rd(i));
    if (i == 26) m_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 32; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 ready", {7'b0, ready}, 8'h00);
    for (int i = 0; i < 32; i++) read_chk("R1 reset read", i);

    for (int i = 0; i < 32; i++) do_w(i, 8'((i * 37 + 11) & 255));
    do_w(8'h25, 8'hFF);
    for (int i = 0; i < 32; i++) begin
      if (i == 29)        read_chk("R9 echo", i);
      else if (wr_ok(i))  read_chk("R2 stored", i);
      else                read_chk("R4 ignored", i);
    end
    read_chk("R4 high index", 8'h25);

    set_idx(8'h05);
    access_w(1'b0, 8'h5A, 1'b1);
    read_chk("R3 cs high write", 5);
    read_chk("R3 echo kept", 29);

    do_w(8'h14, 8'h4D);
    chk("R10 ready set", {7'b0, ready}, 8'h01);
    do_w(8'h14, 8'h4C);
    chk("R10 ready clear", {7'b0, ready}, 8'h00);

    for (int p = 0; p < 16; p++) begin
      @(negedge clk); evt = 4'(p);
      @(negedge clk); evt = 0;
      repeat (2) @(negedge clk);
      chk("R5 irq level", {7'b0, irq_n}, (p == 0) ? 8'h01 : 8'h00);
      m_req = map_evt(4'(p));
      read_chk("R5 request bits", 26);
      chk("R6 irq released", {7'b0, irq_n}, 8'h01);
      read_chk("R6 bits cleared", 26);
    end

    for (int d = 0; d < 6; d++) begin
      @(negedge clk); evt = 4'b0100;
      @(negedge clk); evt = 0;
      set_idx(8'h1A);
      @(negedge clk); cs_n = 0; a0 = 0; rd_n = 0;
      repeat (4) @(negedge clk);
      chk("R6 snapshot", dout, 8'h04);
      rd_n = 1;
      repeat (d) @(negedge clk);
      evt = 4'b0100;
      @(negedge clk); evt = 0;
      repeat (6) @(negedge clk);
      cs_n = 1;
      chk("R7 same-cycle pending", {7'b0, irq_n}, (d >= 2) ? 8'h00 : 8'h01);
      m_req = (d >= 2) ? 8'h04 : 8'h00;
      read_chk("R7 request after race", 26);
    end

    set_idx(8'h12);
    for (int k = 0; k < 5; k++) begin
      int base;
      logic [7:0] val;
      base = scnt;
      val = 8'(k * 3 + 8'h40);
      @(negedge clk); cs_n = 0; a0 = 0; din = val; wr_n = 0;
      repeat (4) @(negedge clk);
      chk("R11 no action while low", 8'(scnt - base), 8'h00);
      wr_n = 1;
      repeat (4) @(negedge clk);
      cs_n = 1;
      chk("R8 one strobe", 8'(scnt - base), 8'h01);
      chk("R8 window", {6'b0, lsel}, 8'h02);
      chk("R8 data", ldata, val);
      last_dw = 8'h12;
    end
    do_w(8'h13, 8'hC3);
    chk("R8 window 3", {6'b0, lsel}, 8'h03);
    chk("R8 data 3", ldata, 8'hC3);
    do_w(8'h11, 8'h3C);
    chk("R8 window 1", {6'b0, lsel}, 8'h01);
    read_chk("R8 window not stored", 8'h12);
    read_chk("R9 echo after stream", 29);

    finish_run();
  end
endmodule